// File: doc/BRIEF.md
# Paged Half-Word Window onto a 32-bit Internal Bus

This block lets a 16-bit management register port reach a 32-bit internal address/data bus. The serial framing in front of it has already been decoded into a 5-bit register number, read and write strobes, and 16-bit data. A page register chooses what the upper half of the register space means. With the bridge page selected, a window of half-word staging registers holds a 32-bit write address, a 32-bit write data word, a 32-bit read address and a captured 32-bit read result. On every other page those register numbers are ordinary storage.

Software stages the high half of a word first and then the low half. Writing the low half of the write data commits the word to the internal bus. Writing the low half of the read address starts an internal read, and the result is captured into the read-data halves. In auto-increment mode the write address steps by one word after each commit, so a stream of high/low pairs fills consecutive words for bulk loading. In fixed mode the address stays put, which suits repeated read-modify-write of one location. Launches that arrive while the bus is still busy wait in a small in-order queue.

Top module: `pbus_bridge`

## Requirements
- R1: After synchronous reset every register reads 0, the page is 0, `busy` is low and `bus_valid` is low.
- R2: Register 0x1F is the page select on every page and reads back the last value written; any register read returns its data on `reg_rdata` one clock after the cycle holding `reg_rd`.
- R3: On page 4, register 0x10 is the mode register and reads back what was written; bit 15 set selects auto-increment, bit 15 clear selects fixed address.
- R4: On page 4, a write to 0x14 launches exactly one internal write to address {0x11,0x12} with data {0x13, value written to 0x14}; a write to 0x13 alone launches nothing.
- R5: In fixed mode, registers 0x11 and 0x12 hold their values after a committed write.
- R6: On page 4, a write to 0x16 launches an internal read of address {0x15, value written}; once the bus acknowledges, 0x17 returns bits 31:16 and 0x18 bits 15:0 of the read word.
- R7: In auto-increment mode the 32-bit write address {0x11,0x12} advances by 4 after each committed word, carrying from the low half into the high half.
- R8: `busy` is high from the cycle after any launch until every queued launch has completed; up to QUEUE_DEPTH launches made while busy are issued in order and none is lost.
- R9: On any page other than 4, registers 0x10 to 0x18 are plain storage that never starts a bus transaction and leaves the page-4 staging registers unchanged.
- R10: Once `bus_valid` is high it stays high with `bus_write`, `bus_addr` and `bus_wdata` unchanged until the cycle `bus_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 5 | Management register number |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data, valid one clock after `reg_rd` |
| busy | output | 1 | A launch is queued or on the bus |
| bus_valid | output | 1 | Internal bus request valid |
| bus_write | output | 1 | 1 for write, 0 for read |
| bus_addr | output | 32 | Internal bus address |
| bus_wdata | output | 32 | Internal bus write data |
| bus_ready | input | 1 | Internal bus acknowledge |
| bus_rdata | input | 32 | Internal bus read data, sampled with `bus_ready` |

## Verification
The embedded properties watch the request hold rule on the internal bus, the address behaviour after each commit in both modes, `busy` following a launch, and the queue never being pushed when full or popped when empty. What only the scenarios show is the end-to-end content: that the bus memory model ends up with the right words at the right addresses, that a burst keeps its order through the queue while the memory is slow, that read halves land in the right registers, and that off-page accesses start no transaction and disturb none of the staging state.

// File: rtl/pbus_bridge_pkg.sv
package pbus_bridge_pkg;
  parameter int unsigned REG_AW = 5;
  parameter int unsigned REG_DW = 16;
  parameter int unsigned BUS_AW = 2 * REG_DW;
  parameter int unsigned BUS_DW = 2 * REG_DW;

  localparam logic [REG_AW-1:0] RN_MODE  = 5'h10;
  localparam logic [REG_AW-1:0] RN_WA_HI = 5'h11;
  localparam logic [REG_AW-1:0] RN_WA_LO = 5'h12;
  localparam logic [REG_AW-1:0] RN_WD_HI = 5'h13;
  localparam logic [REG_AW-1:0] RN_WD_LO = 5'h14;
  localparam logic [REG_AW-1:0] RN_RA_HI = 5'h15;
  localparam logic [REG_AW-1:0] RN_RA_LO = 5'h16;
  localparam logic [REG_AW-1:0] RN_RD_HI = 5'h17;
  localparam logic [REG_AW-1:0] RN_RD_LO = 5'h18;
  localparam logic [REG_AW-1:0] RN_PAGE  = 5'h1F;

  localparam logic [REG_DW-1:0] BRIDGE_PAGE = 16'd4;
  localparam int unsigned       INCR_BIT    = REG_DW - 1;
  localparam int unsigned       WORD_BYTES  = BUS_DW / 8;

  typedef struct packed {
    logic              is_write;
    logic [BUS_AW-1:0] addr;
    logic [BUS_DW-1:0] data;
  } launch_t;
endpackage

// File: rtl/pbus_launch_fifo.sv
module pbus_launch_fifo #(
  parameter int unsigned WIDTH = 65,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] slot_q [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count_q;
  logic             do_pop;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign do_pop = pop && !empty;
  assign empty  = (count_q == '0);
  assign full   = (count_q == CW'(DEPTH));
  assign head   = slot_q[rd_ptr];

  // storage without reset so it can map to distributed or block RAM
  always_ff @(posedge clk) begin
    if (push) slot_q[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (push)   wr_ptr <= step(wr_ptr);
      if (do_pop) rd_ptr <= step(rd_ptr);
      count_q <= count_q + CW'(push) - CW'(do_pop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push |-> (!full || pop)); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty); // R8
endmodule

// File: rtl/pbus_bus_master.sv
module pbus_bus_master
  import pbus_bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  launch_t           head,
  input  logic              empty,
  output logic              pop,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [BUS_AW-1:0] bus_addr,
  output logic [BUS_DW-1:0] bus_wdata,
  input  logic              bus_ready,
  input  logic [BUS_DW-1:0] bus_rdata,
  output logic              rsp_valid,
  output logic [BUS_DW-1:0] rsp_data
);
  // next request loads in the same cycle the current one is accepted
  assign pop       = !empty && (!bus_valid || bus_ready);
  assign rsp_valid = bus_valid && bus_ready && !bus_write;
  assign rsp_data  = bus_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_valid <= 1'b0;
      bus_write <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else if (pop) begin
      bus_valid <= 1'b1;
      bus_write <= head.is_write;
      bus_addr  <= head.addr;
      bus_wdata <= head.data;
    end else if (bus_ready) begin
      bus_valid <= 1'b0;
    end
  end

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) &&
                                   $stable(bus_wdata) && $stable(bus_write))); // R10
endmodule

// File: rtl/pbus_reg_window.sv
module pbus_reg_window
  import pbus_bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              rsp_valid,
  input  logic [BUS_DW-1:0] rsp_data,
  output logic              launch_valid,
  output launch_t           launch
);
  localparam int unsigned NREG = 1 << REG_AW;

  logic [REG_DW-1:0] page_q, mode_q;
  logic [REG_DW-1:0] wa_hi, wa_lo, wd_hi, wd_lo;
  logic [REG_DW-1:0] ra_hi, ra_lo, rd_hi, rd_lo;
  logic [REG_DW-1:0] plain_q [NREG];
  logic [REG_DW-1:0] rd_mux;
  logic [BUS_AW-1:0] wa_word;
  logic              in_window;
  logic              commit_wr;

  assign wa_word   = {wa_hi, wa_lo};
  assign in_window = (page_q == BRIDGE_PAGE) && (reg_addr >= RN_MODE) &&
                     (reg_addr <= RN_RD_LO);
  assign commit_wr = reg_wr && in_window && (reg_addr == RN_WD_LO);

  always_comb begin
    launch_valid    = reg_wr && in_window &&
                      ((reg_addr == RN_WD_LO) || (reg_addr == RN_RA_LO));
    launch.is_write = (reg_addr == RN_WD_LO);
    launch.addr     = launch.is_write ? wa_word : {ra_hi, reg_wdata};
    launch.data     = {wd_hi, reg_wdata};
  end

  // plain storage shared by all non-bridge register numbers
  for (genvar g = 0; g < NREG; g++) begin : g_plain
    always_ff @(posedge clk) begin
      if (rst)
        plain_q[g] <= '0;
      else if (reg_wr && !in_window && (reg_addr == REG_AW'(g)) && (reg_addr != RN_PAGE))
        plain_q[g] <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0; mode_q <= '0;
      wa_hi  <= '0; wa_lo  <= '0;
      wd_hi  <= '0; wd_lo  <= '0;
      ra_hi  <= '0; ra_lo  <= '0;
      rd_hi  <= '0; rd_lo  <= '0;
    end else begin
      if (reg_wr && reg_addr == RN_PAGE) begin
        page_q <= reg_wdata;
      end else if (reg_wr && in_window) begin
        unique case (reg_addr)
          RN_MODE:  mode_q <= reg_wdata;
          RN_WA_HI: wa_hi  <= reg_wdata;
          RN_WA_LO: wa_lo  <= reg_wdata;
          RN_WD_HI: wd_hi  <= reg_wdata;
          RN_WD_LO: begin
            wd_lo <= reg_wdata;
            if (mode_q[INCR_BIT]) {wa_hi, wa_lo} <= wa_word + BUS_AW'(WORD_BYTES);
          end
          RN_RA_HI: ra_hi  <= reg_wdata;
          RN_RA_LO: ra_lo  <= reg_wdata;
          default: ; // read-data halves ignore writes
        endcase
      end
      if (rsp_valid) {rd_hi, rd_lo} <= rsp_data;
    end
  end

  always_comb begin
    rd_mux = plain_q[reg_addr];
    if (reg_addr == RN_PAGE) begin
      rd_mux = page_q;
    end else if (in_window) begin
      unique case (reg_addr)
        RN_MODE:  rd_mux = mode_q;
        RN_WA_HI: rd_mux = wa_hi;
        RN_WA_LO: rd_mux = wa_lo;
        RN_WD_HI: rd_mux = wd_hi;
        RN_WD_LO: rd_mux = wd_lo;
        RN_RA_HI: rd_mux = ra_hi;
        RN_RA_LO: rd_mux = ra_lo;
        RN_RD_HI: rd_mux = rd_hi;
        default:  rd_mux = rd_lo;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  AST_FIXED_ADDR: assert property (@(posedge clk) disable iff (rst)
    (commit_wr && !mode_q[INCR_BIT]) |=> (wa_word == $past(wa_word))); // R5
  AST_INCR_ADDR: assert property (@(posedge clk) disable iff (rst)
    (commit_wr && mode_q[INCR_BIT]) |=>
      (wa_word == $past(wa_word) + BUS_AW'(WORD_BYTES))); // R7
endmodule

// File: rtl/pbus_bridge.sv
module pbus_bridge
  import pbus_bridge_pkg::*;
#(
  parameter int unsigned QUEUE_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [4:0]  reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        busy,
  output logic        bus_valid,
  output logic        bus_write,
  output logic [31:0] bus_addr,
  output logic [31:0] bus_wdata,
  input  logic        bus_ready,
  input  logic [31:0] bus_rdata
);
  localparam int unsigned ENTRY_W = $bits(launch_t);

  launch_t           launch, head;
  logic              launch_valid;
  logic              q_empty, q_full, q_pop;
  logic              rsp_valid;
  logic [BUS_DW-1:0] rsp_data;
  logic              unused_full;

  assign unused_full = q_full;
  assign busy        = !q_empty || bus_valid;

  pbus_reg_window u_window (
    .clk, .rst, .reg_addr, .reg_wr, .reg_rd, .reg_wdata, .reg_rdata,
    .rsp_valid, .rsp_data, .launch_valid, .launch
  );

  pbus_launch_fifo #(.WIDTH(ENTRY_W), .DEPTH(QUEUE_DEPTH)) u_queue (
    .clk, .rst,
    .push      (launch_valid),
    .push_data (launch),
    .pop       (q_pop),
    .head      (head),
    .empty     (q_empty),
    .full      (q_full)
  );

  pbus_bus_master u_master (
    .clk, .rst, .head,
    .empty (q_empty),
    .pop   (q_pop),
    .bus_valid, .bus_write, .bus_addr, .bus_wdata, .bus_ready, .bus_rdata,
    .rsp_valid, .rsp_data
  );

  AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (rst)
    launch_valid |=> busy); // R8
endmodule

// File: tb/pbus_bridge_tb.sv
module pbus_bridge_tb_top;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        busy, bus_valid, bus_write, bus_ready = 1'b0;
  logic [31:0] bus_addr, bus_wdata, bus_rdata = '0;

  int checks = 0, errors = 0, txn_cnt = 0;
  logic [31:0] mem_model [logic [31:0]];
  logic [15:0] exp_q [$];
  string       tag_q [$];
  logic        rd_seen = 1'b0;

  always #2 clk = ~clk;

  pbus_bridge dut_i (
    .clk, .rst, .reg_addr, .reg_wr, .reg_rd, .reg_wdata, .reg_rdata, .busy,
    .bus_valid, .bus_write, .bus_addr, .bus_wdata, .bus_ready, .bus_rdata
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    return mem_model.exists(a) ? mem_model[a] : 32'h0;
  endfunction

  // memory model: acknowledges each request LAT negedges after it is seen
  initial begin
    int wait_cnt = 0;
    logic [31:0] seen_addr = '0, seen_data = '0;
    forever begin
      @(negedge clk);
      if (bus_ready) begin
        bus_ready = 1'b0;
        wait_cnt  = 0;
      end else if (bus_valid) begin
        if (wait_cnt == 0) begin
          seen_addr = bus_addr;
          seen_data = bus_wdata;
        end
        wait_cnt++;
        if (wait_cnt == LAT) begin
          chk("R10 request held", {bus_addr ^ seen_addr} | {bus_wdata ^ seen_data}, 32'h0);
          bus_ready = 1'b1;
          bus_rdata = mem_rd(bus_addr);
          if (bus_write) mem_model[bus_addr] = bus_wdata;
          txn_cnt++;
        end
      end
    end
  end

  // scoreboard monitor
  always @(posedge clk) rd_seen <= reg_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: read result %h with no expected item", reg_rdata);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {16'h0, reg_rdata}, {16'h0, e});
      end
    end
  end

  task automatic reg_write(input logic [4:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [4:0] a, input logic [15:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (busy && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic finish_run();
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n0;
    mem_model[32'h400] = 32'hDEADBEEF;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 busy after reset", {31'h0, busy}, 32'h0);
    chk("R1 bus_valid after reset", {31'h0, bus_valid}, 32'h0);
    reg_read(5'h1F, 16'h0000, "R1 page reset");
    reg_read(5'h14, 16'h0000, "R1 storage reset");

    // R2 / R3
    reg_write(5'h1F, 16'h0004);
    reg_read(5'h1F, 16'h0004, "R2 page readback");
    reg_write(5'h10, 16'h8000);
    reg_read(5'h10, 16'h8000, "R3 mode readback");
    reg_write(5'h10, 16'h0000);

    // R4 / R5: fixed-address write
    reg_write(5'h11, 16'h0000);
    reg_write(5'h12, 16'h0100);
    n0 = txn_cnt;
    reg_write(5'h13, 16'h1234);
    repeat (5) @(negedge clk);
    chk("R4 high half alone starts nothing", txn_cnt, n0);
    reg_write(5'h14, 16'h5678);
    chk("R8 busy after launch", {31'h0, busy}, 32'h1);
    wait_idle();
    chk("R4 committed word", mem_rd(32'h100), 32'h12345678);
    chk("R4 one transaction", txn_cnt, n0 + 1);
    reg_read(5'h12, 16'h0100, "R5 addr low kept");
    reg_read(5'h11, 16'h0000, "R5 addr high kept");
    reg_write(5'h13, 16'hAAAA);
    reg_write(5'h14, 16'h5555);
    wait_idle();
    chk("R5 same location rewritten", mem_rd(32'h100), 32'hAAAA5555);
    reg_read(5'h12, 16'h0100, "R5 addr low kept again");

    // R6: reads
    reg_write(5'h15, 16'h0000);
    reg_write(5'h16, 16'h0100);
    wait_idle();
    reg_read(5'h17, 16'hAAAA, "R6 read high half");
    reg_read(5'h18, 16'h5555, "R6 read low half");
    reg_write(5'h16, 16'h0400);
    wait_idle();
    reg_read(5'h17, 16'hDEAD, "R6 preloaded high");
    reg_read(5'h18, 16'hBEEF, "R6 preloaded low");

    // R7 / R8: auto-increment burst, back to back while memory is slow
    reg_write(5'h10, 16'h8000);
    reg_write(5'h11, 16'h0000);
    reg_write(5'h12, 16'h0200);
    n0 = txn_cnt;
    for (int i = 0; i < 5; i++) begin
      reg_write(5'h13, 16'h1000 + 16'(i));
      reg_write(5'h14, 16'h2000 + 16'(i));
    end
    wait_idle();
    chk("R8 no launch lost", txn_cnt, n0 + 5);
    for (int i = 0; i < 5; i++)
      chk("R7 burst word in order", mem_rd(32'h200 + 32'(4 * i)),
          {16'h1000 + 16'(i), 16'h2000 + 16'(i)});
    reg_read(5'h12, 16'h0214, "R7 address advanced");

    // R7: carry between halves
    reg_write(5'h12, 16'hFFFC);
    reg_write(5'h13, 16'h7777);
    reg_write(5'h14, 16'h8888);
    wait_idle();
    chk("R7 word at carry boundary", mem_rd(32'h0000FFFC), 32'h77778888);
    reg_read(5'h11, 16'h0001, "R7 carry into high");
    reg_read(5'h12, 16'h0000, "R7 low wrapped");

    // R9: other page
    reg_write(5'h1F, 16'h0000);
    n0 = txn_cnt;
    reg_write(5'h13, 16'hBEEF);
    reg_write(5'h14, 16'hCAFE);
    reg_write(5'h16, 16'h0200);
    repeat (6) @(negedge clk);
    chk("R9 no transaction off page", txn_cnt, n0);
    chk("R9 not busy off page", {31'h0, busy}, 32'h0);
    reg_read(5'h14, 16'hCAFE, "R9 plain storage");
    reg_read(5'h16, 16'h0200, "R9 plain storage read addr");
    reg_write(5'h1F, 16'h0004);
    reg_read(5'h14, 16'h8888, "R9 staging low untouched");
    reg_read(5'h13, 16'h7777, "R9 staging high untouched");
    reg_read(5'h16, 16'h0400, "R9 read addr untouched");

    finish_run();
  end
endmodule